// File: doc/BRIEF.md
# Multi-mode 4:2:2 YCbCr input receiver

This block accepts 4:2:2 YCbCr video on a 16-bit parallel pixel bus clocked by a single input clock. It turns the bus into a stream of pixel pairs. Each pair holds one luma sample, one chroma sample and a flag that says whether the chroma is Cb or Cr. Three bus formats are supported:

- Single data rate, with luma and chroma on separate bytes.
- Double data rate on the upper lanes, with luma and chroma on opposite clock edges.
- Interleaved words on the upper lanes, one word per rising edge at twice the pixel rate.

Embedded timing reference codes are recognised in all formats. Their flag bits are reported, and the code words are removed from the pixel stream.

All samples are widened to 10 bits. An 8-bit sample is left-justified, with zeros in its two lowest bits. Optional external horizontal and vertical sync inputs are delayed to line up with the pixel path. The output is valid-only and has no ready: the video source cannot be paused, so the block applies no back-pressure. A consumer must accept every `pix_valid` cycle. Configuration pins are plain levels and are meant to change only while the bus is idle.

Top module: `ycc422_rx`

## Requirements
- R1: `cfg_mode` selects the format: 001 is 16-bit single rate, 010 is double rate, 111 is interleaved. Any other value produces neither `pix_valid` nor `tr_valid`, whatever is on the bus.
- R2: In single-rate mode, luma is `pbus[15:8]` and chroma is `pbus[7:0]`, each placed in sample bits 9:2 with bits 1:0 zero. `cfg_wide` has no effect in this mode.
- R3: In double-rate and interleaved modes, a word is taken from `pbus[15:6]` when `cfg_wide` is 1. When `cfg_wide` is 0 it is taken from `pbus[15:8]`, with two zero LSBs appended. The remaining low bus bits are ignored.
- R4: In double-rate mode, `cfg_luma_edge` = 11 takes chroma on a rising edge and its luma on the following falling edge. Any other value takes chroma on a falling edge and its luma on the following rising edge.
- R5: In interleaved mode, words alternate chroma then luma, starting with chroma after reset. The word after any word sequence preamble, 0, 0, X is always taken as chroma, which realigns a stream that has slipped by one word.
- R6: A timing code is a pair with chroma equal to the preamble and luma 0, followed by a pair with chroma 0 whose luma is the XY word. The preamble is 3FF in 10-bit width and 3FC (FF left-justified) otherwise. Single-rate mode always uses 3FC. Neither pair of a code is output as a pixel.
- R7: On a code, `tr_valid` pulses for one cycle. Sample bits 8, 7 and 6 of the XY word, which are bits 6, 5 and 4 of its upper byte, load `tr_field`, `tr_vblank` and `tr_eav`. These outputs hold until the next code.
- R8: `pix_cr` is 0 (Cb) on the first pixel after reset and after every code with `tr_eav` = 0. It toggles on every pixel. A code with `tr_eav` = 1 leaves the phase unchanged.
- R9: When a pair is complete on rising edge k, `pix_valid` is high for the one cycle after rising edge k+1. For luma on the falling edge, a pair is complete on the rising edge that follows the luma's falling edge. A code's `tr_valid` follows the same rule.
- R10: `hs_out` and `vs_out` repeat `hs_in` and `vs_in` two rising edges later. They are held at 0 while the mode is interleaved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel bus clock; both edges are used in double-rate mode |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 3 | Bus format select |
| cfg_luma_edge | input | 2 | Edge that carries luma in double-rate mode |
| cfg_wide | input | 1 | 10-bit word width for double-rate and interleaved modes |
| pbus | input | 16 | Parallel pixel bus |
| hs_in | input | 1 | External horizontal sync |
| vs_in | input | 1 | External vertical sync |
| pix_valid | output | 1 | One cycle per output pixel pair |
| pix_y | output | 10 | Luma sample |
| pix_c | output | 10 | Chroma sample |
| pix_cr | output | 1 | Chroma phase: 0 Cb, 1 Cr |
| tr_valid | output | 1 | One cycle per decoded timing code |
| tr_field | output | 1 | Field flag of the last code |
| tr_vblank | output | 1 | Vertical blanking flag of the last code |
| tr_eav | output | 1 | 1 for end-of-active code, 0 for start-of-active code |
| hs_out | output | 1 | Delayed horizontal sync |
| vs_out | output | 1 | Delayed vertical sync |

## Verification
Two functions meet at the boundary between a timing code and the pixel that follows it. In that cycle the phase reset from a start-of-active code must apply to the pixel that comes directly after the code's second pair, while the toggle from the previous pixel must not. The bench provokes this by driving codes and pixels back to back with no idle words between them, in every bus format. A scoreboard that models the phase from the requirements judges the phase of each pixel. A code whose words slip by one in interleaved mode checks the same boundary from the other side: the realignment must happen, and the code must not be reported.

// File: rtl/ycc_rx_pkg.sv
package ycc_rx_pkg;
  localparam int unsigned BUS_W    = 16;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned SAMPLE_W = 10;
  localparam int unsigned PAD_W    = SAMPLE_W - BYTE_W;
  localparam int unsigned HIST_N   = 3;
  localparam int unsigned FLD_BIT  = SAMPLE_W - 2;
  localparam int unsigned VBL_BIT  = SAMPLE_W - 3;
  localparam int unsigned EAV_BIT  = SAMPLE_W - 4;

  typedef enum logic [2:0] {
    FMT_SDR16 = 3'b001,
    FMT_DDR   = 3'b010,
    FMT_ILV   = 3'b111
  } fmt_e;

  typedef logic [SAMPLE_W-1:0] smp_t;

  typedef struct packed {
    smp_t c;
    smp_t y;
  } pair_t;
endpackage

// File: rtl/ycc_ddr_capture.sv
module ycc_ddr_capture
  import ycc_rx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  luma_fall,
  input  smp_t  lane_w,
  output pair_t pair_o
);
  smp_t fall_q;
  smp_t rise_q;

  // falling-edge capture, consumed only in the rising domain
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= '0;
    else        fall_q <= lane_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_q <= '0;
    else        rise_q <= lane_w;
  end

  // luma on falling edge: chroma came on the previous rising edge
  // luma on rising edge: chroma came on the falling edge just before
  always_comb begin
    if (luma_fall) begin
      pair_o.c = rise_q;
      pair_o.y = fall_q;
    end else begin
      pair_o.c = fall_q;
      pair_o.y = lane_w;
    end
  end
endmodule

// File: rtl/ycc_ilv_assembler.sv
module ycc_ilv_assembler
  import ycc_rx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  smp_t  word_i,
  input  smp_t  pre_i,
  output pair_t pair_o,
  output logic  emit_o
);
  smp_t hist_q [HIST_N];
  smp_t c_hold_q;
  logic slot_y_q;
  logic xy_hit;

  assign xy_hit = (hist_q[HIST_N-1] == pre_i) && (hist_q[1] == '0) && (hist_q[0] == '0);
  assign emit_o = en && slot_y_q;
  assign pair_o.c = c_hold_q;
  assign pair_o.y = word_i;

  generate
    for (genvar i = 0; i < HIST_N; i++) begin : g_hist
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  hist_q[i] <= '0;
        else if (en) hist_q[i] <= (i == 0) ? word_i : hist_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_hold_q <= '0;
      slot_y_q <= 1'b0;
    end else if (en) begin
      if (!slot_y_q) c_hold_q <= word_i;
      slot_y_q <= xy_hit ? 1'b0 : !slot_y_q;
    end
  end

  // R5: a pair needs two words, so emits never sit in adjacent cycles
  a_r5_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    emit_o |=> !emit_o);
endmodule

// File: rtl/ycc_trs_parser.sv
module ycc_trs_parser
  import ycc_rx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  input  pair_t pair_i,
  input  smp_t  pre_i,
  output logic  pix_valid,
  output smp_t  pix_y,
  output smp_t  pix_c,
  output logic  pix_cr,
  output logic  tr_valid,
  output logic  tr_field,
  output logic  tr_vblank,
  output logic  tr_eav
);
  logic lead_q;
  logic phase_q;
  logic is_lead;
  logic is_xy;

  assign is_lead = (pair_i.c == pre_i) && (pair_i.y == '0);
  assign is_xy   = lead_q && (pair_i.c == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_q    <= 1'b0;
      phase_q   <= 1'b0;
      pix_valid <= 1'b0;
      pix_y     <= '0;
      pix_c     <= '0;
      pix_cr    <= 1'b0;
      tr_valid  <= 1'b0;
      tr_field  <= 1'b0;
      tr_vblank <= 1'b0;
      tr_eav    <= 1'b0;
    end else begin
      pix_valid <= 1'b0;
      tr_valid  <= 1'b0;
      if (in_valid) begin
        lead_q <= !lead_q && is_lead;
        if (is_xy) begin
          tr_valid  <= 1'b1;
          tr_field  <= pair_i.y[FLD_BIT];
          tr_vblank <= pair_i.y[VBL_BIT];
          tr_eav    <= pair_i.y[EAV_BIT];
          if (!pair_i.y[EAV_BIT]) phase_q <= 1'b0;
        end else if (!(is_lead && !lead_q)) begin
          pix_valid <= 1'b1;
          pix_y     <= pair_i.y;
          pix_c     <= pair_i.c;
          pix_cr    <= phase_q;
          phase_q   <= !phase_q;
        end
      end
    end
  end

  // R6: an input pair becomes either a pixel or part of a code, never both
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_valid && tr_valid));
  // R7: the second pair of a code is always preceded by a swallowed lead pair
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tr_valid |=> !tr_valid);
  // R8: adjacent pixels alternate chroma phase
  a_r8_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && $past(pix_valid)) |-> (pix_cr != $past(pix_cr)));
  // R8: a pixel right after a start-of-active code is Cb
  a_r8_sav_cb: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && $past(tr_valid) && !$past(tr_eav)) |-> !pix_cr);
endmodule

// File: rtl/ycc422_rx.sv
module ycc422_rx
  import ycc_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          cfg_mode,
  input  logic [1:0]          cfg_luma_edge,
  input  logic                cfg_wide,
  input  logic [BUS_W-1:0]    pbus,
  input  logic                hs_in,
  input  logic                vs_in,
  output logic                pix_valid,
  output logic [SAMPLE_W-1:0] pix_y,
  output logic [SAMPLE_W-1:0] pix_c,
  output logic                pix_cr,
  output logic                tr_valid,
  output logic                tr_field,
  output logic                tr_vblank,
  output logic                tr_eav,
  output logic                hs_out,
  output logic                vs_out
);
  localparam int unsigned SYNC_N = 2;

  logic  is_sdr, is_ddr, is_ilv;
  smp_t  lane_w, pre_w;
  pair_t sdr_pair, ddr_pair, ilv_pair;
  logic  ilv_emit;
  logic  s1_valid;
  pair_t s1_pair;
  smp_t  s1_pre;
  logic [SYNC_N-1:0] sync_d, sync_q;

  assign is_sdr = (cfg_mode == FMT_SDR16);
  assign is_ddr = (cfg_mode == FMT_DDR);
  assign is_ilv = (cfg_mode == FMT_ILV);

  // shared-lane word: wide uses the top SAMPLE_W bits, narrow the top byte
  assign lane_w = cfg_wide ? pbus[BUS_W-1 -: SAMPLE_W]
                           : {pbus[BUS_W-1 -: BYTE_W], {PAD_W{1'b0}}};
  assign sdr_pair.y = {pbus[BUS_W-1 -: BYTE_W], {PAD_W{1'b0}}};
  assign sdr_pair.c = {pbus[BYTE_W-1:0], {PAD_W{1'b0}}};
  assign pre_w = (is_sdr || !cfg_wide) ? {{BYTE_W{1'b1}}, {PAD_W{1'b0}}} : '1;

  ycc_ddr_capture u_ddr (
    .clk       (clk),
    .rst_n     (rst_n),
    .luma_fall (cfg_luma_edge == 2'b11),
    .lane_w    (lane_w),
    .pair_o    (ddr_pair)
  );

  ycc_ilv_assembler u_ilv (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (is_ilv),
    .word_i (lane_w),
    .pre_i  (pre_w),
    .pair_o (ilv_pair),
    .emit_o (ilv_emit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_pair  <= '0;
      s1_pre   <= '0;
    end else begin
      s1_pre <= pre_w;
      if (is_sdr) begin
        s1_valid <= 1'b1;
        s1_pair  <= sdr_pair;
      end else if (is_ddr) begin
        s1_valid <= 1'b1;
        s1_pair  <= ddr_pair;
      end else if (is_ilv) begin
        s1_valid <= ilv_emit;
        s1_pair  <= ilv_pair;
      end else begin
        s1_valid <= 1'b0;
      end
    end
  end

  ycc_trs_parser u_parse (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (s1_valid),
    .pair_i    (s1_pair),
    .pre_i     (s1_pre),
    .pix_valid (pix_valid),
    .pix_y     (pix_y),
    .pix_c     (pix_c),
    .pix_cr    (pix_cr),
    .tr_valid  (tr_valid),
    .tr_field  (tr_field),
    .tr_vblank (tr_vblank),
    .tr_eav    (tr_eav)
  );

  // sync path matches the two-stage pixel latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_d <= '0;
      sync_q <= '0;
    end else begin
      sync_d <= {vs_in, hs_in};
      sync_q <= is_ilv ? '0 : sync_d;
    end
  end
  assign hs_out = sync_q[0];
  assign vs_out = sync_q[1];

  // R1: unsupported formats feed nothing into the parser
  a_r1_idle_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_sdr || is_ddr || is_ilv) |=> !s1_valid);
  // R10: external syncs are silenced in interleaved mode
  a_r10_ilv_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(is_ilv) |-> (!hs_out && !vs_out));
endmodule

// File: tb/sim_ycc422_rx.sv
module sim_ycc422_rx;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  mode;
  logic [1:0]  edge_sel;
  logic        wide;
  logic [15:0] pbus;
  logic        hs_in, vs_in;
  logic        pix_valid, pix_cr, tr_valid, tr_field, tr_vblank, tr_eav, hs_out, vs_out;
  logic [9:0]  pix_y, pix_c;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  string cur_req = "R2";
  logic [20:0] pixq[$];
  logic [2:0]  trq[$];
  bit ph = 0;

  always #4 clk = ~clk;

  ycc422_rx u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(mode), .cfg_luma_edge(edge_sel), .cfg_wide(wide),
    .pbus(pbus), .hs_in(hs_in), .vs_in(vs_in), .pix_valid(pix_valid), .pix_y(pix_y),
    .pix_c(pix_c), .pix_cr(pix_cr), .tr_valid(tr_valid), .tr_field(tr_field),
    .tr_vblank(tr_vblank), .tr_eav(tr_eav), .hs_out(hs_out), .vs_out(vs_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] place(input logic [9:0] w);
    return wide ? {w, 6'b100101} : {w[9:2], 8'h5A};
  endfunction
  function automatic logic [9:0] msk(input logic [9:0] w);
    return wide ? w : {w[9:2], 2'b00};
  endfunction
  function automatic logic [9:0] pre_word();
    return wide ? 10'h3FF : 10'h3FC;
  endfunction

  // scoreboard model built from R8
  function automatic void exp_pix(input logic [9:0] c, input logic [9:0] y);
    pixq.push_back({ph, y, c});
    ph = ~ph;
  endfunction
  function automatic void exp_code(input logic [7:0] xy);
    trq.push_back(xy[6:4]);
    if (!xy[4]) ph = 1'b0;
  endfunction

  // monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      if (pix_valid) begin
        if (pixq.size() == 0) chk("R6 unexpected pixel", {11'b0, pix_cr, pix_y, pix_c}, 32'hDEAD);
        else chk({cur_req, " R8 pixel"}, {11'b0, pix_cr, pix_y, pix_c}, {11'b0, pixq.pop_front()});
      end
      if (tr_valid) begin
        if (trq.size() == 0) chk("R7 unexpected code", {tr_field, tr_vblank, tr_eav}, 32'hDEAD);
        else chk("R7 code flags", {tr_field, tr_vblank, tr_eav}, {29'b0, trq.pop_front()});
      end
    end
  end

  // drivers
  task automatic idle(input int n);
    @(posedge clk); #1 mode = 3'b000;
    repeat (n) @(posedge clk);
  endtask
  task automatic sdr(input logic [7:0] y, input logic [7:0] c);
    @(posedge clk); #1 mode = 3'b001; pbus = {y, c};
  endtask
  task automatic sdr_pix(input logic [7:0] y, input logic [7:0] c);
    sdr(y, c); exp_pix({c, 2'b00}, {y, 2'b00});
  endtask
  task automatic sdr_code(input logic [7:0] xy);
    sdr(8'h00, 8'hFF); sdr(xy, 8'h00); exp_code(xy);
  endtask
  task automatic ddr_pair(input logic [9:0] c, input logic [9:0] y);
    if (edge_sel == 2'b11) begin
      @(negedge clk); #1 pbus = place(c);
      @(posedge clk); #1 mode = 3'b010; pbus = place(y);
    end else begin
      @(posedge clk); #1 mode = 3'b010; pbus = place(c);
      @(negedge clk); #1 pbus = place(y);
    end
  endtask
  task automatic ddr_pix(input logic [9:0] c, input logic [9:0] y);
    ddr_pair(c, y); exp_pix(msk(c), msk(y));
  endtask
  task automatic ddr_code(input logic [7:0] xy);
    ddr_pair(pre_word(), 10'h000); ddr_pair(10'h000, {xy, 2'b00}); exp_code(xy);
  endtask
  task automatic ilv_word(input logic [9:0] w);
    @(posedge clk); #1 mode = 3'b111; pbus = place(w);
  endtask
  task automatic ilv_pix(input logic [9:0] c, input logic [9:0] y);
    ilv_word(c); ilv_word(y); exp_pix(msk(c), msk(y));
  endtask
  task automatic ilv_code(input logic [7:0] xy);
    ilv_word(pre_word()); ilv_word(10'h000); ilv_word(10'h000); ilv_word({xy, 2'b00});
    exp_code(xy);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode = 3'b000; edge_sel = 2'b00; wide = 1'b0;
    pbus = 16'h0; hs_in = 1'b0; vs_in = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset pix_valid", pix_valid, 0);
    chk("R1 reset tr_valid", tr_valid, 0);
    chk("R10 reset hs_out", hs_out, 0);

    // R2: single rate, wide ignored, codes back to back with pixels
    cur_req = "R2"; wide = 1'b1;
    sdr_code(8'h80);
    sdr_pix(8'h12, 8'h34); sdr_pix(8'h56, 8'h78); sdr_pix(8'h9A, 8'hBC);
    sdr_code(8'h9D);
    sdr_pix(8'h11, 8'h22); sdr_pix(8'h33, 8'h44);
    sdr_code(8'hEC);
    sdr_pix(8'h55, 8'h66);
    idle(4);

    // R9: latency of a single pair
    sdr_pix(8'hA5, 8'h3C);
    @(posedge clk); #1 mode = 3'b000;
    @(negedge clk); chk("R9 one edge after capture", pix_valid, 0);
    @(negedge clk); chk("R9 two edges after capture", pix_valid, 1);
    @(negedge clk); chk("R9 single cycle pulse", pix_valid, 0);
    idle(2);

    // R10: sync pass-through outside interleaved mode
    @(posedge clk); #1 hs_in = 1'b1; vs_in = 1'b1;
    @(posedge clk);
    @(negedge clk); chk("R10 hs after one edge", hs_out, 0);
    @(negedge clk); chk("R10 hs after two edges", hs_out, 1);
    chk("R10 vs after two edges", vs_out, 1);
    @(posedge clk); #1 hs_in = 1'b0; vs_in = 1'b0;
    idle(3);

    // R3 and R4: double rate, 8-bit, luma on rising edge
    cur_req = "R3"; wide = 1'b0; edge_sel = 2'b00;
    ddr_code(8'h80);
    ddr_pix(10'h101, 10'h206); ddr_pix(10'h2AB, 10'h155); ddr_pix(10'h0F3, 10'h30C);
    ddr_code(8'hF1);
    ddr_pix(10'h048, 10'h1E0);
    idle(4);

    // R4: luma on falling edge, 10-bit
    cur_req = "R4"; wide = 1'b1; edge_sel = 2'b11;
    ddr_code(8'hEC);
    ddr_pix(10'h101, 10'h207); ddr_pix(10'h2AB, 10'h156); ddr_pix(10'h0F3, 10'h30D);
    ddr_code(8'h9D);
    ddr_pix(10'h049, 10'h1E1); ddr_pix(10'h3FE, 10'h001);
    idle(4);

    // R4: value 01 behaves as luma on rising edge
    edge_sel = 2'b01;
    ddr_code(8'h80);
    ddr_pix(10'h123, 10'h234); ddr_pix(10'h345, 10'h056);
    idle(4);

    // R5 and R10: interleaved 10-bit with syncs active
    cur_req = "R5"; wide = 1'b1; edge_sel = 2'b00;
    hs_in = 1'b1; vs_in = 1'b1;
    ilv_code(8'h80);
    ilv_pix(10'h111, 10'h222); ilv_pix(10'h333, 10'h044); ilv_pix(10'h155, 10'h2AA);
    ilv_code(8'hB6);
    ilv_pix(10'h0C3, 10'h13C);
    @(negedge clk);
    chk("R10 hs ignored in interleaved", hs_out, 0);
    chk("R10 vs ignored in interleaved", vs_out, 0);
    idle(1);
    hs_in = 1'b0; vs_in = 1'b0;
    idle(4);

    // R5: slipped by one word, realigned after the code's fourth word
    wide = 1'b0;
    ilv_word(10'h2A8);
    ilv_word(pre_word()); exp_pix(10'h2A8, pre_word());
    ilv_word(10'h000); ilv_word(10'h000); exp_pix(10'h000, 10'h000);
    ilv_word({8'h80, 2'b00});
    ilv_pix(10'h104, 10'h208); ilv_pix(10'h30C, 10'h010);
    ilv_code(8'h9D);
    ilv_pix(10'h0A0, 10'h1B0);
    ilv_code(8'h80);
    ilv_pix(10'h0A4, 10'h1B4);
    idle(4);

    // R1: unsupported modes produce nothing
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1 mode = (i < 3) ? 3'b011 : 3'b100;
      pbus = (i % 2 == 0) ? 16'h00FF : 16'h8000;
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 no pixel in unsupported mode", pix_valid, 0);
      chk("R1 no code in unsupported mode", tr_valid, 0);
    end
    idle(6);

    chk("R9 all pixels delivered", pixq.size(), 0);
    chk("R7 all codes delivered", trq.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule